// File: doc/BRIEF.md
# Address-covered SECDED read checker

This block sits on the read path of a non-volatile memory whose error-correcting code protects both the stored data and the location it was read from. Each read delivers a 128-bit line that is split into two 64-bit halves, each with its own stored 8-bit check byte. Both halves are checked in parallel against the same line address. Each lane recomputes check bits over its data and the address, XORs them with the stored byte to form a syndrome, and decides what the read is worth. A single flipped data bit is repaired in place. A single flipped check bit is reported as repaired and the data is left as it is. Anything that points at an address bit, or that looks like two flips, is reported as uncorrectable.

The code is an odd-weight-column code with 8 check bits over 83 protected bits. Data bits 0 to 63 come first, then address bits 64 to 82. Lanes whose data and check byte are all zeros or all ones are treated as unprogrammed or erased and pass through unchecked. A control input turns checking off. This input is meant to be driven by a control bit that resets to the enabled state. Results appear one clock after the read strobe.

Each lane resolves to one of six named verdicts: LV_OFF (checking disabled), LV_SKIP (blank lane), LV_CLEAN (zero syndrome), LV_FIX_CHK (error in the check byte), LV_FIX_DATA (error in a data bit, repaired) and LV_FATAL (address or multi-bit error). The verdict is recomputed for every read, so there are no transitions that carry over between reads. The output register only captures the verdict of the read that was strobed.

Top module: `secded_read_chk`

## Requirements
- R1: While rst_n is low, out_valid, out_sbe and out_ue are 0 and out_data is all zeros.
- R2: out_valid is high in exactly the cycle after a cycle with rd_valid high. out_sbe and out_ue can be nonzero only in such a cycle, so each flag is a one-cycle pulse for one read.
- R3: A line whose check bytes match its data and address yields out_data equal to rd_data with both flags 0 in both lanes.
- R4: A single flipped data bit in a lane is corrected in out_data, and that lane's out_sbe bit is set while its out_ue bit stays 0.
- R5: A single flipped bit in a lane's stored check byte sets that lane's out_sbe bit and leaves out_data equal to rd_data.
- R6: Two flipped bits in one lane (data and data, or data and check) set that lane's out_ue bit. That lane's out_data is then equal to rd_data, unchanged.
- R7: A read whose rd_addr differs in any of bits 21..3 from the address used to build the check bytes sets out_ue in both lanes and repairs nothing. Bits 2..0 of rd_addr have no effect.
- R8: Lane 0 checks rd_data[63:0] against rd_chk[7:0], and lane 1 checks rd_data[127:64] against rd_chk[15:8]. out_sbe[i] and out_ue[i] report lane i, and an error in one lane leaves the other lane's flags and data untouched.
- R9: A lane whose 64 data bits and 8 check bits are all zeros, or all ones, reports no error and passes its data unchanged, whatever the address.
- R10: With chk_en low, out_data equals rd_data and both flag vectors are 0, whatever errors are present.
- R11: Check bit j is the XOR of the protected bits whose column has bit j set. The protected vector is data bits 0..63 followed by address bits 64..82 (rd_addr bits 3..21). Columns are assigned in order: first every 8-bit value of weight 3 in increasing numeric order, then every value of weight 5 in increasing order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | Checking enable; low passes data through unflagged |
| rd_valid | input | 1 | Read strobe; the inputs below are sampled while it is high |
| rd_addr | input | 22 | Byte-level read address; bits 21..3 are covered by the code |
| rd_data | input | 128 | Raw line read from the array |
| rd_chk | input | 16 | Stored check bytes, lane 0 in [7:0], lane 1 in [15:8] |
| out_valid | output | 1 | Result strobe, one cycle after rd_valid |
| out_data | output | 128 | Corrected line |
| out_sbe | output | 2 | Per-lane corrected-error flag |
| out_ue | output | 2 | Per-lane uncorrectable-error flag |

## Verification
The bench builds the block with its default parameters: two 64-bit lanes, 8 check bits, 19 covered address bits and 3 ignored low bits. These values cover the full 83-column code. Every covered address bit can be flipped on its own, and a repair can be walked across the whole lane boundary at bit 64. The bench encodes lines with its own model of the column order, injects single and double flips in data, check and address bits, and drives blank-lane patterns at nonzero addresses. The blank patterns would fail the check if the bypass were missing.

// File: rtl/secded_pkg.sv
package secded_pkg;

    typedef enum logic [2:0] {
        LV_OFF,
        LV_SKIP,
        LV_CLEAN,
        LV_FIX_DATA,
        LV_FIX_CHK,
        LV_FATAL
    } lane_verdict_e;

    // Column value for protected bit k: weight-3 values ascending, then
    // weight-5, then weight-7, over a cw-bit check field.
    function automatic logic [15:0] hsiao_col(input int k, input int cw);
        logic [15:0] res;
        int n;
        res = '0;
        n = 0;
        for (int w = 3; w <= cw; w += 2) begin
            for (int v = 0; v < (1 << cw); v++) begin
                if ($countones(v) == w) begin
                    if (n == k) res = 16'(v);
                    n++;
                end
            end
        end
        return res;
    endfunction

    // Row j of the parity matrix: which protected bits feed check bit j.
    function automatic logic [255:0] row_mask(input int j, input int pw, input int cw);
        logic [255:0] m;
        logic [15:0] c;
        m = '0;
        for (int k = 0; k < pw; k++) begin
            c = hsiao_col(k, cw);
            m[k] = c[j];
        end
        return m;
    endfunction

endpackage

// File: rtl/secded_encode.sv
module secded_encode #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 19,
    parameter int CHK_W  = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [ADDR_W-1:0] addr,
    output logic [CHK_W-1:0]  chk
);
    import secded_pkg::*;

    localparam int PROT_W = DATA_W + ADDR_W;

    logic [PROT_W-1:0] prot;
    assign prot = {addr, data};

    for (genvar j = 0; j < CHK_W; j++) begin : g_row
        localparam logic [255:0] ROW = row_mask(j, PROT_W, CHK_W);
        assign chk[j] = ^(prot & ROW[PROT_W-1:0]);
    end

endmodule

// File: rtl/secded_lane.sv
module secded_lane #(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 19,
    parameter int CHK_W  = 8
) (
    input  logic              en,
    input  logic [DATA_W-1:0] data,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CHK_W-1:0]  stored,
    output logic [DATA_W-1:0] data_out,
    output logic              sbe,
    output logic              ue
);
    import secded_pkg::*;

    localparam int PROT_W = DATA_W + ADDR_W;

    logic [CHK_W-1:0]  calc;
    logic [CHK_W-1:0]  syn;
    logic [PROT_W-1:0] hit;
    logic [DATA_W-1:0] hit_data;
    logic [ADDR_W-1:0] hit_addr;
    logic              blank;
    lane_verdict_e     verdict;

    secded_encode #(
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .CHK_W (CHK_W)
    ) u_enc (
        .data(data),
        .addr(addr),
        .chk (calc)
    );

    assign syn = calc ^ stored;

    // One comparator per protected column locates a single-bit error.
    for (genvar k = 0; k < PROT_W; k++) begin : g_hit
        localparam logic [15:0] COL = hsiao_col(k, CHK_W);
        assign hit[k] = (syn == COL[CHK_W-1:0]);
    end

    assign hit_data = hit[DATA_W-1:0];
    assign hit_addr = hit[PROT_W-1:DATA_W];

    assign blank = ((data == '0) && (stored == '0)) ||
                   ((&data) && (&stored));

    // Verdict selection, highest priority first.
    always_comb begin
        if (!en)                         verdict = LV_OFF;
        else if (blank)                  verdict = LV_SKIP;
        else if (syn == '0)              verdict = LV_CLEAN;
        else if ($countones(syn) == 1)   verdict = LV_FIX_CHK;
        else if (|hit_addr)              verdict = LV_FATAL;
        else if (|hit_data)              verdict = LV_FIX_DATA;
        else                             verdict = LV_FATAL;
    end

    // Output decode per verdict.
    always_comb begin
        data_out = data;
        sbe      = 1'b0;
        ue       = 1'b0;
        unique case (verdict)
            LV_OFF, LV_SKIP, LV_CLEAN: begin
                data_out = data;
            end
            LV_FIX_CHK: begin
                sbe = 1'b1;
            end
            LV_FIX_DATA: begin
                data_out = data ^ hit_data;
                sbe      = 1'b1;
            end
            LV_FATAL: begin
                ue = 1'b1;
            end
            default: begin
                ue = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/secded_read_chk.sv
module secded_read_chk #(
    parameter int LANES    = 2,
    parameter int DATA_W   = 64,
    parameter int ADDR_W   = 19,
    parameter int CHK_W    = 8,
    parameter int ADDR_LSB = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          chk_en,
    input  logic                          rd_valid,
    input  logic [ADDR_W+ADDR_LSB-1:0]    rd_addr,
    input  logic [LANES*DATA_W-1:0]       rd_data,
    input  logic [LANES*CHK_W-1:0]        rd_chk,
    output logic                          out_valid,
    output logic [LANES*DATA_W-1:0]       out_data,
    output logic [LANES-1:0]              out_sbe,
    output logic [LANES-1:0]              out_ue
);
    localparam int LINE_W  = LANES * DATA_W;
    localparam int RADDR_W = ADDR_W + ADDR_LSB;

    logic [ADDR_W-1:0] line_addr;
    logic              addr_lsb_unused;
    logic [LINE_W-1:0] fix_data;
    logic [LANES-1:0]  lane_sbe;
    logic [LANES-1:0]  lane_ue;

    assign line_addr       = rd_addr[RADDR_W-1:ADDR_LSB];
    assign addr_lsb_unused = ^rd_addr[ADDR_LSB-1:0];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        secded_lane #(
            .DATA_W(DATA_W),
            .ADDR_W(ADDR_W),
            .CHK_W (CHK_W)
        ) u_lane (
            .en      (chk_en),
            .data    (rd_data[i*DATA_W +: DATA_W]),
            .addr    (line_addr),
            .stored  (rd_chk[i*CHK_W +: CHK_W]),
            .data_out(fix_data[i*DATA_W +: DATA_W]),
            .sbe     (lane_sbe[i]),
            .ue      (lane_ue[i])
        );
    end

    // Result register: one cycle from strobe to result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sbe   <= '0;
            out_ue    <= '0;
        end else begin
            out_valid <= rd_valid;
            if (rd_valid) begin
                out_data <= fix_data;
                out_sbe  <= lane_sbe;
                out_ue   <= lane_ue;
            end else begin
                out_sbe  <= '0;
                out_ue   <= '0;
            end
        end
    end

    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !out_valid);

    // R2
    flag_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|out_sbe) || (|out_ue)) |-> out_valid);

    // R10
    off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !chk_en) |=>
            (out_sbe == '0 && out_ue == '0 && out_data == $past(rd_data)));

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        // R4
        fix_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_sbe[i] |-> ($countones(out_data[i*DATA_W +: DATA_W] ^
                                       $past(rd_data[i*DATA_W +: DATA_W])) <= 1));

        // R6
        fatal_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_ue[i] |-> (out_data[i*DATA_W +: DATA_W] ==
                           $past(rd_data[i*DATA_W +: DATA_W])));

        // R9
        blank_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_valid && chk_en &&
             (((rd_data[i*DATA_W +: DATA_W] == '0) && (rd_chk[i*CHK_W +: CHK_W] == '0)) ||
              ((&rd_data[i*DATA_W +: DATA_W]) && (&rd_chk[i*CHK_W +: CHK_W]))))
            |=> (!out_sbe[i] && !out_ue[i]));

        // R4
        flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(out_sbe[i] && out_ue[i]));
    end

endmodule

// File: tb/sim_secded_read_chk.sv
module sim_secded_read_chk;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          chk_en;
    logic          rd_valid;
    logic [21:0]   rd_addr;
    logic [127:0]  rd_data;
    logic [15:0]   rd_chk;
    logic          out_valid;
    logic [127:0]  out_data;
    logic [1:0]    out_sbe;
    logic [1:0]    out_ue;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    secded_read_chk u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .chk_en   (chk_en),
        .rd_valid (rd_valid),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .rd_chk   (rd_chk),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_sbe  (out_sbe),
        .out_ue   (out_ue)
    );

    function automatic int weight8(input int v);
        int n = 0;
        for (int b = 0; b < 8; b++) if ((v >> b) & 1) n++;
        return n;
    endfunction

    // Model of R11: walk the column list and XOR in columns of set bits.
    function automatic logic [7:0] tb_enc(input logic [63:0] d, input logic [18:0] a);
        logic [82:0] p;
        logic [7:0]  r;
        int          n;
        p = {a, d};
        r = 8'h00;
        n = 0;
        for (int w = 3; w <= 7; w += 2) begin
            for (int v = 0; v < 256; v++) begin
                if (weight8(v) == w) begin
                    if (n < 83 && p[n]) r ^= 8'(v);
                    n++;
                end
            end
        end
        return r;
    endfunction

    function automatic logic [15:0] make_chk(input logic [127:0] d, input logic [21:0] a);
        return {tb_enc(d[127:64], a[21:3]), tb_enc(d[63:0], a[21:3])};
    endfunction

    function automatic logic [127:0] rnd_line();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic read_line(input logic [127:0] d, input logic [15:0] c,
                             input logic [21:0] a, input logic en,
                             input logic [127:0] exp_d, input logic [1:0] exp_s,
                             input logic [1:0] exp_u, input string req);
        @(negedge clk);
        rd_data  = d;
        rd_chk   = c;
        rd_addr  = a;
        chk_en   = en;
        rd_valid = 1'b1;
        @(negedge clk);
        rd_valid = 1'b0;
        check(out_valid === 1'b1, req, "valid", 128'(out_valid), 128'd1);
        check(out_data === exp_d, req, "data", out_data, exp_d);
        check(out_sbe === exp_s, req, "sbe", 128'(out_sbe), 128'(exp_s));
        check(out_ue === exp_u, req, "ue", 128'(out_ue), 128'(exp_u));
        @(negedge clk);
        check(out_valid === 1'b0 && out_sbe === 2'b00 && out_ue === 2'b00, "R2",
              "pulse", 128'({out_valid, out_sbe, out_ue}), 128'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [127:0] d;
        logic [127:0] e;
        logic [15:0]  c;
        logic [21:0]  a;

        rst_n    = 1'b0;
        chk_en   = 1'b1;
        rd_valid = 1'b0;
        rd_addr  = '0;
        rd_data  = '0;
        rd_chk   = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(out_valid === 1'b0 && out_sbe === 2'b00 && out_ue === 2'b00, "R1",
              "flags", 128'({out_valid, out_sbe, out_ue}), 128'd0);
        check(out_data === 128'd0, "R1", "data", out_data, 128'd0);
        rst_n = 1'b1;

        // R3 / R11: clean lines encoded by the bench model
        for (int t = 0; t < 8; t++) begin
            d = rnd_line();
            a = 22'($urandom);
            read_line(d, make_chk(d, a), a, 1'b1, d, 2'b00, 2'b00, "R3_R11");
        end

        // R4 / R8: single data flips across both lanes
        for (int b = 0; b < 128; b += 7) begin
            d = rnd_line();
            a = 22'($urandom);
            c = make_chk(d, a);
            e = d;
            e[b] = ~e[b];
            read_line(e, c, a, 1'b1, d, (b < 64) ? 2'b01 : 2'b10, 2'b00, "R4_R8");
        end

        // R5: single check-bit flips
        for (int j = 0; j < 16; j++) begin
            d = rnd_line();
            a = 22'($urandom);
            c = make_chk(d, a);
            c[j] = ~c[j];
            read_line(d, c, a, 1'b1, d, (j < 8) ? 2'b01 : 2'b10, 2'b00, "R5");
        end

        // R6: two data bits in lane 0
        d = rnd_line();
        a = 22'($urandom);
        c = make_chk(d, a);
        e = d;
        e[3] = ~e[3];
        e[40] = ~e[40];
        read_line(e, c, a, 1'b1, e, 2'b00, 2'b01, "R6");

        // R6: data plus check bit in lane 1
        d = rnd_line();
        a = 22'($urandom);
        c = make_chk(d, a);
        e = d;
        e[100] = ~e[100];
        c[12] = ~c[12];
        read_line(e, c, a, 1'b1, e, 2'b00, 2'b10, "R6");

        // R7: every covered address bit
        for (int k = 3; k < 22; k++) begin
            d = rnd_line();
            a = 22'($urandom);
            c = make_chk(d, a);
            read_line(d, c, a ^ (22'd1 << k), 1'b1, d, 2'b00, 2'b11, "R7");
        end

        // R7: low address bits ignored
        d = rnd_line();
        a = 22'($urandom);
        c = make_chk(d, a);
        read_line(d, c, a ^ 22'd7, 1'b1, d, 2'b00, 2'b00, "R7");

        // R9: blank lanes at a nonzero address
        d = {64'hFFFF_FFFF_FFFF_FFFF, 64'h0};
        read_line(d, 16'hFF00, 22'h2A_5A5F, 1'b1, d, 2'b00, 2'b00, "R9");
        d = {64'h0, 64'hFFFF_FFFF_FFFF_FFFF};
        read_line(d, 16'h00FF, 22'h15_3C38, 1'b1, d, 2'b00, 2'b00, "R9");

        // R10: disabled, with single and double errors present
        d = rnd_line();
        a = 22'($urandom);
        c = make_chk(d, a);
        e = d;
        e[9] = ~e[9];
        read_line(e, c, a, 1'b0, e, 2'b00, 2'b00, "R10");
        e[70] = ~e[70];
        e[71] = ~e[71];
        read_line(e, c, a, 1'b0, e, 2'b00, 2'b00, "R10");

        // R2: idle cycles carry no flags
        repeat (2) @(negedge clk);
        check(out_valid === 1'b0 && out_sbe === 2'b00 && out_ue === 2'b00, "R2",
              "idle", 128'({out_valid, out_sbe, out_ue}), 128'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule